// File: doc/BRIEF.md
# CAN Test-Mode Pin Router

This block sits between a CAN protocol engine and the two bus pins. It holds a small test register and decides, from that register, what value reaches the transmit pin and what receive bit reaches the protocol engine. The transmit pin can follow the engine, show the sample-point strobe, or be held at either bus level. Silent routing and internal loop-back can be enabled separately, and both can be combined with any transmit-pin code.

The test register can be written only while the test-enable bit of the control register is high. When that bit goes low, every writable field returns to zero and the pins go back to normal routing. The register also shows the live, synchronized level of the receive pin. The buffer-mode bit is not acted on here; it is only passed out as a flag for the message-buffer logic.

Top module: `can_test_pinmux`

## Requirements
- R1: After reset, `test_reg` reads 16'h0080 while `rx_pin` is held recessive (1), `basic_mode` is 0, and `tx_pin` follows `core_tx`.
- R2: A write while `test_en` is low changes no field. `test_reg[6:0]` stays 0 and `tx_pin` keeps following `core_tx`.
- R3: A write while `test_en` is high loads the fields on the next clock edge: bit 0 is buffer mode, bit 3 is silent, bit 4 is loop-back, and bits 6:5 are the transmit code. Bits 15:8, 2:1 and 7 of `wr_data` are ignored. Bits 15:8 and 2:1 of `test_reg` read 0.
- R4: Transmit code 2'b00 with silent clear drives `core_tx` onto `tx_pin`.
- R5: Transmit code 2'b01 drives `sample_pt` onto `tx_pin`.
- R6: Transmit code 2'b10 drives `tx_pin` to 0 (dominant). Code 2'b11 drives it to 1 (recessive).
- R7: With silent set and transmit code 2'b00, `tx_pin` is 1 whatever `core_tx` is. With any other code, the code decides the pin value.
- R8: With loop-back set, `core_rx` equals `core_tx`. With loop-back clear, `core_rx` is the synchronized receive-pin level.
- R9: `test_reg[7]` shows the level `rx_pin` had two clock edges earlier (0 = dominant, 1 = recessive), through a two-flop synchronizer.
- R10: On the first clock edge with `test_en` low, all writable fields clear to 0.
- R11: `basic_mode` equals `test_reg[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| test_en | input | 1 | Test-enable bit from the control register |
| wr_en | input | 1 | Write strobe for the test register |
| wr_data | input | 16 | Write data |
| core_tx | input | 1 | Transmit bit from the protocol engine |
| rx_pin | input | 1 | Raw receive pin |
| sample_pt | input | 1 | Sample-point strobe from the bit timing logic |
| tx_pin | output | 1 | Transmit pin value |
| core_rx | output | 1 | Receive bit presented to the protocol engine |
| test_reg | output | 16 | Test register read value |
| basic_mode | output | 1 | Buffer-mode flag |

## Verification
`tx_pin` and `core_rx` are combinational from the stored fields and the live inputs, so they are due in the same cycle their inputs change. Field writes and the clear on `test_en` low show up one edge after the edge that samples them. The receive monitor lags `rx_pin` by two edges. The bench drives inputs on the falling edge and samples 1 ns later. It counts the rising edges between each stimulus and its check: zero for pin routing, one for field updates, and two for the receive monitor, with one intermediate check to confirm the value has not yet arrived.

// File: rtl/can_test_pinmux.sv
module can_test_pinmux (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        test_en,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        core_tx,
  input  logic        rx_pin,
  input  logic        sample_pt,
  output logic        tx_pin,
  output logic        core_rx,
  output logic [15:0] test_reg,
  output logic        basic_mode
);

  localparam int B_BASIC  = 0;
  localparam int B_SILENT = 3;
  localparam int B_LOOP   = 4;
  localparam int B_TXLO   = 5;
  localparam int B_TXHI   = 6;

  typedef enum logic [1:0] {TX_CORE = 2'b00, TX_SAMPLE = 2'b01,
                            TX_DOM = 2'b10, TX_REC = 2'b11} tx_code_t;

  logic     basic_q, silent_q, loop_q;
  tx_code_t txc_q;
  logic     rx_s1, rx_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      basic_q  <= 1'b0;
      silent_q <= 1'b0;
      loop_q   <= 1'b0;
      txc_q    <= TX_CORE;
    end else if (!test_en) begin
      basic_q  <= 1'b0;
      silent_q <= 1'b0;
      loop_q   <= 1'b0;
      txc_q    <= TX_CORE;
    end else if (wr_en) begin
      basic_q  <= wr_data[B_BASIC];
      silent_q <= wr_data[B_SILENT];
      loop_q   <= wr_data[B_LOOP];
      txc_q    <= tx_code_t'(wr_data[B_TXHI:B_TXLO]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
    end else begin
      rx_s1 <= rx_pin;
      rx_s2 <= rx_s1;
    end
  end

  always_comb begin
    unique case (txc_q)
      TX_CORE:   tx_pin = silent_q ? 1'b1 : core_tx;
      TX_SAMPLE: tx_pin = sample_pt;
      TX_DOM:    tx_pin = 1'b0;
      TX_REC:    tx_pin = 1'b1;
      default:   tx_pin = 1'b1;
    endcase
  end

  assign core_rx    = loop_q ? core_tx : rx_s2;
  assign basic_mode = basic_q;
  assign test_reg   = {8'h00, rx_s2, txc_q, loop_q, silent_q, 2'b00, basic_q};

endmodule

// File: rtl/can_test_pinmux_chk.sv
module can_test_pinmux_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        test_en,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic        core_tx,
  input logic        rx_pin,
  input logic        tx_pin,
  input logic        core_rx,
  input logic [15:0] test_reg,
  input logic        basic_mode
);

  logic [1:0] age;
  logic       rxd1, rxd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age  <= 2'd0;
      rxd1 <= 1'b1;
      rxd2 <= 1'b1;
    end else begin
      if (age != 2'd2) age <= age + 2'd1;
      rxd1 <= rx_pin;
      rxd2 <= rxd1;
    end
  end

  p_lock_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |=> (test_reg[6:0] == 7'd0));

  p_write_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && wr_en) |=> (test_reg[6:5] == $past(wr_data[6:5])) &&
                           (test_reg[4:3] == $past(wr_data[4:3])));

  p_zero_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_reg[15:8] == 8'd0) && (test_reg[2:1] == 2'd0));

  p_dominant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_reg[6:5] == 2'b10) |-> !tx_pin);

  p_recessive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_reg[6:5] == 2'b11) |-> tx_pin);

  p_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (test_reg[6:5] == 2'b00 && test_reg[3]) |-> tx_pin);

  p_loop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    test_reg[4] |-> (core_rx == core_tx));

  p_rx_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !test_reg[4] |-> (core_rx == test_reg[7]));

  p_rx_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (test_reg[7] == rxd2));

  p_basic_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    basic_mode == test_reg[0]);

endmodule

bind can_test_pinmux can_test_pinmux_chk u_chk (.*);

// File: tb/can_test_pinmux_bench.sv
`timescale 1ns/1ps
module can_test_pinmux_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'h0000;
  logic        core_tx = 1'b0;
  logic        rx_pin = 1'b1;
  logic        sample_pt = 1'b0;
  logic        tx_pin, core_rx, basic_mode;
  logic [15:0] test_reg;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  can_test_pinmux u_can_test_pinmux (.*);

  // {tx[1:0], silent, loop, core_tx, sample_pt, exp_tx_pin, exp_core_rx}
  localparam int NV = 12;
  localparam logic [7:0] VEC [NV] = '{
    8'b00000100, 8'b00001010, 8'b00100010, 8'b01000110,
    8'b01001000, 8'b10001100, 8'b11000010, 8'b00011011,
    8'b00010000, 8'b00110010, 8'b10111001, 8'b01100110
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    core_tx = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1 test_reg", test_reg, 16'h0080);
    chk("R1 basic", {15'd0, basic_mode}, 16'd0);
    chk("R1 tx", {15'd0, tx_pin}, 16'd0);
    @(negedge clk);
    rst_n = 1'b1;
    core_tx = 1'b1;
    #1;
    chk("R1 tx follows core", {15'd0, tx_pin}, 16'd1);

    // R2: write with test_en low ignored
    @(negedge clk);
    test_en = 1'b0; wr_en = 1'b1; wr_data = 16'h007F;
    @(negedge clk);
    wr_en = 1'b0; core_tx = 1'b0;
    #1;
    chk("R2 fields", test_reg, 16'h0080);
    chk("R2 tx", {15'd0, tx_pin}, 16'd0);

    // table, rx_pin dominant
    rx_pin = 1'b0;
    settle();
    settle();
    for (int i = 0; i < NV; i++) begin
      logic [7:0] v;
      logic       b;
      v = VEC[i];
      b = i[0];
      @(negedge clk);
      test_en = 1'b1; wr_en = 1'b1;
      wr_data = {8'hFF, 1'b1, v[7:6], v[4], v[5], 2'b11, b};
      @(negedge clk);
      wr_en = 1'b0; wr_data = 16'h0000;
      core_tx = v[3]; sample_pt = v[2];
      #1;
      // R3 readback, R11 flag
      chk("R3 readback", test_reg, {8'h00, 1'b0, v[7:6], v[4], v[5], 2'b00, b});
      chk("R11 basic", {15'd0, basic_mode}, {15'd0, b});
      // R4 R5 R6 R7 pin routing
      chk("R4/R5/R6/R7 tx_pin", {15'd0, tx_pin}, {15'd0, v[1]});
      // R8 receive routing
      chk("R8 core_rx", {15'd0, core_rx}, {15'd0, v[0]});
    end

    // R10: clear on test_en low
    @(negedge clk);
    test_en = 1'b1; wr_en = 1'b1; wr_data = 16'h0059; // tx=10 loop silent basic
    @(negedge clk);
    wr_en = 1'b0; core_tx = 1'b1; test_en = 1'b0;
    #1;
    chk("R10 still forced before edge", {15'd0, tx_pin}, 16'd0);
    settle();
    chk("R10 fields cleared", test_reg, 16'h0000);
    chk("R10 tx normal", {15'd0, tx_pin}, 16'd1);
    chk("R10 basic cleared", {15'd0, basic_mode}, 16'd0);

    // R9: two-edge receive latency
    @(negedge clk);
    rx_pin = 1'b1;
    settle();
    chk("R9 after one edge", {15'd0, test_reg[7]}, 16'd0);
    settle();
    chk("R9 after two edges", {15'd0, test_reg[7]}, 16'd1);
    chk("R8 core_rx from pin", {15'd0, core_rx}, 16'd1);

    // R7: silent with core dominant stays recessive
    @(negedge clk);
    test_en = 1'b1; wr_en = 1'b1; wr_data = 16'h0008;
    @(negedge clk);
    wr_en = 1'b0; core_tx = 1'b0;
    #1;
    chk("R7 silent recessive", {15'd0, tx_pin}, 16'd1);

    finish_run();
  end

endmodule